// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator

This block drives four independent pulse-width-modulated outputs from a single clock. Software programs each channel through a simple word-wide register port (byte address, write data, write strobe, read strobe, read data) with no handshake: a write lands on the clock edge where the write strobe is high. Read data is returned one cycle after the read strobe.

Each channel has its own control word, period and duty value. The control word holds the enable, the polarity and a 10-bit clock prescaler. Every prescaler tick advances the channel's period counter. The output sits in its active phase for the first `duty` ticks of every `period`-tick cycle, and in its inactive phase for the rest. Polarity decides whether the active phase is high or low.

Top module: `pwm_quad`

## Requirements
- R1: After reset every control, period and duty register reads 0. Every channel is disabled, and because polarity bit 0 means inverted, every output sits at its inactive level, which is 1.
- R2: Channel n (n = 0..3) owns byte addresses (n+1)*0x10 to (n+1)*0x10+0xF. Within that bank, offset 0x0 is the control word, 0x4 is the period (16 bits) and 0x8 is the duty (16 bits). Read data appears the cycle after the read strobe and is 0 when no read is requested.
- R3: In the control word, bit 0 enables the channel, bit 1 sets polarity (1 = output high in the active phase, 0 = output low in the active phase), and bits 11:2 hold the divider. The 12 bits read back exactly as written, and bits 31:12 read as 0.
- R4: An enabled channel's period counter advances once every `divider` clocks. A divider of 0 behaves as 1.
- R5: Counting clocks from the edge that enables the channel, with D the effective divider and P the period, the output is active while (clocks mod P*D) < min(duty,P)*D, and inactive otherwise.
- R6: A duty of 0 keeps the output inactive for the whole cycle. A duty greater than or equal to the period keeps it active for the whole cycle. A period of 0 keeps it inactive.
- R7: A disabled channel drives the inactive level for its current polarity and holds its counters at zero, so enabling it starts a fresh cycle from count zero.
- R8: Reads return 0 at offsets 0x00–0x0F, at offset 0xC within a bank, and above the last bank. Writes to those addresses change no register. Bits 31:16 of period and duty read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for bus and counters |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte address of the register access |
| busWrData | input | 32 | Write data |
| busWrEn | input | 1 | Write strobe, one access per cycle |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 32 | Read data, valid the cycle after busRdEn |
| pwmOut | output | 4 | One PWM output per channel |

## Verification
The bench keeps a behavioural model of every channel: a phase counter that is reset by the enabling write. On every clock it compares all four outputs against that model, so an off-by-one in the prescaler or period wrap shows up as an edge that comes one or more clocks early or late. The corner cases are a divider of 0, which a wrong design would treat as 1024 or as stuck, and a duty of 0 or above the period, which a wrong design would glitch or wrap. A period of 0 and polarity inversion are also covered, since a wrong design would leave the idle level stuck at 0. Re-enabling a channel after disabling it must start a new cycle, not resume the old count. Writes to holes in the map and to the low bank are checked for leaking into channel registers.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
  localparam int DIV_W  = 10;
  localparam int CNT_W  = 16;
  localparam int MODE_W = DIV_W + 2;

  // control-to-datapath bundle, one per channel
  typedef struct packed {
    logic             enable;
    logic             polarity;
    logic [DIV_W-1:0] divider;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] duty;
  } chanCtrl_t;
endpackage

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  output chanCtrl_t         chanCtrl [NUM_CH]
);
  localparam int STRIDE_LSB = 4;
  localparam int SEL_W      = ADDR_W - STRIDE_LSB;
  localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [MODE_W-1:0] modeQ   [NUM_CH];
  logic [CNT_W-1:0]  periodQ [NUM_CH];
  logic [CNT_W-1:0]  dutyQ   [NUM_CH];

  logic [SEL_W-1:0]  bankSel;
  logic [1:0]        wordSel;
  logic              bankHit;
  logic              regHit;
  logic [CH_W-1:0]   chSel;
  logic [DATA_W-1:0] readMux;
  logic              unusedBits;

  assign bankSel    = busAddr[ADDR_W-1:STRIDE_LSB];
  assign wordSel    = busAddr[STRIDE_LSB-1:2];
  assign unusedBits = ^{busAddr[1:0], busWrData[DATA_W-1:CNT_W]};

  // bank n sits one stride above the base
  always_comb begin
    bankHit = 1'b0;
    chSel   = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (bankSel == SEL_W'(c + 1)) begin
        bankHit = 1'b1;
        chSel   = CH_W'(c);
      end
    end
    regHit = bankHit && (wordSel != 2'd3);
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        modeQ[ch]   <= '0;
        periodQ[ch] <= '0;
        dutyQ[ch]   <= '0;
      end else if (busWrEn && regHit && chSel == CH_W'(ch)) begin
        case (wordSel)
          2'd0:    modeQ[ch]   <= busWrData[MODE_W-1:0];
          2'd1:    periodQ[ch] <= busWrData[CNT_W-1:0];
          2'd2:    dutyQ[ch]   <= busWrData[CNT_W-1:0];
          default: ;
        endcase
      end
    end

    assign chanCtrl[ch] = '{enable:   modeQ[ch][0],
                            polarity: modeQ[ch][1],
                            divider:  modeQ[ch][MODE_W-1:2],
                            period:   periodQ[ch],
                            duty:     dutyQ[ch]};
  end

  always_comb begin
    readMux = '0;
    if (regHit) begin
      case (wordSel)
        2'd0:    readMux = DATA_W'(modeQ[chSel]);
        2'd1:    readMux = DATA_W'(periodQ[chSel]);
        2'd2:    readMux = DATA_W'(dutyQ[chSel]);
        default: readMux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       busRdData <= '0;
    else if (busRdEn) busRdData <= readMux;
    else              busRdData <= '0;
  end

  // R8: unmapped reads come back as zero
  a_r8_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    busRdEn && !regHit |=> busRdData == '0);

  // R2: an idle read port returns zero
  a_r2_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !busRdEn |=> busRdData == '0);
endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan
  import pwm_quad_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  chanCtrl_t ctrl,
  output logic      pwmOut
);
  logic [DIV_W-1:0] preCnt;
  logic [DIV_W-1:0] divEff;
  logic [CNT_W-1:0] perCnt;
  logic [CNT_W:0]   perInc;
  logic             tick;
  logic             phaseActive;

  assign divEff = (ctrl.divider == '0) ? DIV_W'(1) : ctrl.divider;
  assign tick   = (preCnt == divEff - DIV_W'(1));
  assign perInc = {1'b0, perCnt} + (CNT_W+1)'(1);

  always_ff @(posedge clk) begin
    if (!rst_n || !ctrl.enable) begin
      preCnt <= '0;
      perCnt <= '0;
    end else if (tick) begin
      preCnt <= '0;
      perCnt <= (perInc >= {1'b0, ctrl.period}) ? '0 : perInc[CNT_W-1:0];
    end else begin
      preCnt <= preCnt + DIV_W'(1);
    end
  end

  assign phaseActive = (ctrl.period != '0) && (perCnt < ctrl.duty);
  assign pwmOut      = (ctrl.enable && phaseActive) ? ctrl.polarity : ~ctrl.polarity;

  // R4: the period counter only moves on a prescaler tick
  a_r4_count_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.enable && !tick |=> $stable(perCnt));

  // R7: enabling starts from a cleared count
  a_r7_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl.enable) |-> (perCnt == '0 && preCnt == '0));

  // R6: zero duty never reaches the active level
  a_r6_zero_duty_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.enable && ctrl.duty == '0 |-> pwmOut == ~ctrl.polarity);

  // R5: every cycle opens in the active phase when duty is nonzero
  a_r5_cycle_opens_active: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.enable && perCnt == '0 && ctrl.period != '0 && ctrl.duty != '0
      |-> pwmOut == ctrl.polarity);
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  output logic [NUM_CH-1:0] pwmOut
);
  chanCtrl_t chanCtrl [NUM_CH];

  pwm_quad_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .busRdData (busRdData),
    .chanCtrl  (chanCtrl)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    pwm_quad_chan chan_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctrl   (chanCtrl[ch]),
      .pwmOut (pwmOut[ch])
    );
  end
endmodule

// File: tb/pwm_quad_tb_top.sv
module pwm_quad_tb_top;
  localparam int NUM_CH = 4;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWrData = '0;
  logic              busWrEn = 1'b0;
  logic              busRdEn = 1'b0;
  logic [DATA_W-1:0] busRdData;
  logic [NUM_CH-1:0] pwmOut;

  int checks = 0;
  int fails  = 0;
  bit modelOn = 1'b0;
  bit done = 1'b0;

  int shMode [NUM_CH];
  int shPer  [NUM_CH];
  int shDuty [NUM_CH];
  int phase  [NUM_CH];

  always #4 clk = ~clk;

  pwm_quad #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrData(busWrData),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busRdData(busRdData), .pwmOut(pwmOut)
  );

  // behavioural model: clocks elapsed since the enabling write
  always @(posedge clk) begin
    for (int c = 0; c < NUM_CH; c++) begin
      if (!rst_n) begin
        shMode[c] = 0; shPer[c] = 0; shDuty[c] = 0; phase[c] = 0;
      end else begin
        bit wasOn;
        wasOn = (shMode[c] & 1) != 0;
        phase[c] = wasOn ? phase[c] + 1 : 0;
        if (busWrEn && (int'(busAddr) >> 4) == c + 1) begin
          case ((int'(busAddr) >> 2) & 3)
            0: begin
              shMode[c] = int'(busWrData & 32'hFFF);
              if ((busWrData[0]) && !wasOn) phase[c] = 0;
            end
            1: shPer[c]  = int'(busWrData & 32'hFFFF);
            2: shDuty[c] = int'(busWrData & 32'hFFFF);
            default: ;
          endcase
        end
      end
    end
  end

  function automatic logic expOut(int c);
    int dv, p, d;
    bit en, pol, act;
    en  = (shMode[c] & 1) != 0;
    pol = ((shMode[c] >> 1) & 1) != 0;
    dv  = (shMode[c] >> 2) & 1023;
    if (dv == 0) dv = 1;
    p   = shPer[c];
    d   = (shDuty[c] < p) ? shDuty[c] : p;
    act = en && p != 0 && ((phase[c] % (p * dv)) < d * dv);
    return act ? pol : !pol;
  endfunction

  function automatic string tagFor(int c);
    if ((shMode[c] & 1) == 0) return "R7";
    if (((shMode[c] >> 2) & 1023) == 0) return "R4";
    if (shPer[c] == 0 || shDuty[c] == 0 || shDuty[c] >= shPer[c]) return "R6";
    return "R5";
  endfunction

  // compare every output against the model on every clock (R4 R5 R6 R7)
  always @(negedge clk) begin
    if (modelOn && !done) begin
      for (int c = 0; c < NUM_CH; c++) begin
        checks++;
        if (pwmOut[c] !== expOut(c)) begin
          fails++;
          $display("FAIL %s ch%0d phase %0d: pwmOut=%0b expected %0b",
                   tagFor(c), c, phase[c], pwmOut[c], expOut(c));
        end
      end
    end
  end

  task automatic busWrite(input int addr, input logic [DATA_W-1:0] data);
    busAddr = ADDR_W'(addr); busWrData = data; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input int addr, input logic [DATA_W-1:0] exp, input string tag);
    busAddr = ADDR_W'(addr); busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    checks++;
    if (busRdData !== exp) begin
      fails++;
      $display("FAIL %s read 0x%02h: got 0x%08h expected 0x%08h", tag, addr, busRdData, exp);
    end
  endtask

  task automatic setChan(input int c, input int dv, input int per, input int dut, input bit pol, input bit en);
    busWrite((c + 1) * 16 + 4, DATA_W'(per));
    busWrite((c + 1) * 16 + 8, DATA_W'(dut));
    busWrite((c + 1) * 16, DATA_W'((dv << 2) | (int'(pol) << 1) | int'(en)));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    modelOn = 1'b1;

    // R1: reset state
    checks++;
    if (pwmOut !== 4'hF) begin
      fails++;
      $display("FAIL R1 reset outputs: got %b expected 1111", pwmOut);
    end
    for (int c = 0; c < NUM_CH; c++) begin
      busRead((c + 1) * 16,     32'h0, "R1");
      busRead((c + 1) * 16 + 4, 32'h0, "R1");
      busRead((c + 1) * 16 + 8, 32'h0, "R1");
    end

    // R8: holes and the low bank ignore writes and read zero
    busWrite(8'h00, 32'hFFFF_FFFF);
    busWrite(8'h04, 32'hFFFF_FFFF);
    busWrite(8'h1C, 32'hFFFF_FFFF);
    busWrite(8'h50, 32'hFFFF_FFFF);
    busWrite(8'hF4, 32'hFFFF_FFFF);
    busRead(8'h00, 32'h0, "R8");
    busRead(8'h04, 32'h0, "R8");
    busRead(8'h1C, 32'h0, "R8");
    busRead(8'h50, 32'h0, "R8");
    busRead(8'hF4, 32'h0, "R8");
    for (int c = 0; c < NUM_CH; c++) begin
      busRead((c + 1) * 16,     32'h0, "R8");
      busRead((c + 1) * 16 + 4, 32'h0, "R8");
      busRead((c + 1) * 16 + 8, 32'h0, "R8");
    end

    // R2 R3 R8: field readback with junk in unused upper bits
    busWrite(8'h14, 32'hABCD_0005);
    busWrite(8'h18, 32'h1234_0002);
    busWrite(8'h10, 32'hFFFF_F00E);
    busRead(8'h10, 32'h0000_000E, "R3");
    busRead(8'h14, 32'h0000_0005, "R2");
    busRead(8'h18, 32'h0000_0002, "R8");
    busWrite(8'h40, 32'h0000_0FFE);
    busRead(8'h40, 32'h0000_0FFE, "R3");
    busRead(8'h30, 32'h0, "R2");

    // four distinct configurations running together
    setChan(0, 3, 5, 2, 1'b1, 1'b1);
    setChan(1, 0, 4, 1, 1'b0, 1'b1);
    setChan(2, 2, 3, 7, 1'b1, 1'b1);
    setChan(3, 1, 6, 0, 1'b1, 1'b1);
    busRead(8'h10, 32'h0000_000F, "R3");
    repeat (300) @(negedge clk);

    // R7: disable, then re-enable with a new shape
    busWrite(8'h10, 32'h0000_000E);
    repeat (25) @(negedge clk);
    setChan(0, 0, 0, 3, 1'b1, 1'b0);
    busWrite(8'h10, 32'h0000_0003);
    repeat (30) @(negedge clk);
    busWrite(8'h10, 32'h0000_0000);
    setChan(0, 5, 4, 4, 1'b0, 1'b1);
    repeat (100) @(negedge clk);

    // R4: largest divider on channel 1
    busWrite(8'h20, 32'h0);
    setChan(1, 1023, 2, 1, 1'b1, 1'b1);
    repeat (4200) @(negedge clk);

    // R7: disabled channel follows polarity changes
    busWrite(8'h40, 32'h0000_0002);
    repeat (5) @(negedge clk);
    busWrite(8'h40, 32'h0000_0000);
    repeat (5) @(negedge clk);
    checks++;
    if (pwmOut[3] !== 1'b1) begin
      fails++;
      $display("FAIL R7 disabled inverted ch3: got %b expected 1", pwmOut[3]);
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired: got hang expected completion");
      summary();
      $finish;
    end
  end
endmodule